// File: doc/BRIEF.md
# Half-Rate Paired Word Writer

This block takes a stream of narrow half-words on a single fast clock and packs each two consecutive accepted half-words into one full-width word. Each packed word goes to an internal memory of 128 entries, and only one memory write can start every other fast cycle. The memory write bus is driven from a second holding stage, not from the assembly register. This means write enable, address and both halves of the data stay unchanged for two whole fast cycles, and the memory takes the word at the end of the second cycle. Because of this, the half-word that arrived late gets the same two-cycle setup margin as the one that arrived early.

The input is a valid/ready stream. A producer that sees `in_valid` high and `in_ready` low must hold `in_data` unchanged and keep `in_valid` high until the half-word is taken. At full input rate the block never stalls. Only one event drops `in_ready`: a flush pulse that arrives while an unpaired half-word is waiting. A flush pulse sends that lone half-word to memory with a zeroed upper half, and the input is held off for that one cycle. The block reports the address the next word will use and gives a one-cycle pulse each time that address rolls over. A combinational read port lets the surrounding logic look at any stored entry.

Top module: `pair_pack_writer`

## Requirements
- R1: After reset, `mem_we` is 0, `wr_ptr` is 0, `wrap_pulse` is 0 and `in_ready` is 1, and no unpaired half-word is waiting.
- R2: In each pair of accepted half-words, the first one lands in bits [15:0] of the packed word and the second one lands in bits [31:16].
- R3: After the clock edge that completes a pair, `mem_we` is high for exactly two cycles, with `mem_addr` and `mem_wdata` unchanged across both cycles.
- R4: The memory stores the word at the clock edge that ends the second write cycle. From that point on, `rd_data` at that address returns the word.
- R5: Each packed word takes the address shown on `wr_ptr` at its handoff. `wr_ptr` then steps by one and rolls over from 127 to 0. `wrap_pulse` is high for exactly the one cycle in which `wr_ptr` first shows 0 after the rollover.
- R6: While `flush` is low, `in_ready` stays high, so one half-word per cycle is accepted indefinitely.
- R7: A flush pulse while an unpaired half-word is waiting writes that half-word as a word with bits [31:16] equal to zero, and `in_ready` is low in that cycle.
- R8: A flush pulse while no half-word is waiting has no effect. No write starts, `wr_ptr` does not move and `in_ready` stays high.
- R9: A half-word that is offered while `in_ready` is low is not taken. It is accepted in a later cycle as the first half-word of the next pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input half-word offered |
| in_ready | output | 1 | Block can take the offered half-word |
| in_data | input | 16 | Input half-word |
| flush | input | 1 | Single-cycle request to write a waiting unpaired half-word |
| mem_we | output | 1 | Memory write enable from the holding stage |
| mem_addr | output | 7 | Memory write address from the holding stage |
| mem_wdata | output | 32 | Packed word from the holding stage |
| wr_ptr | output | 7 | Address the next packed word will use |
| wrap_pulse | output | 1 | One-cycle pulse when the address rolls over to 0 |
| rd_addr | input | 7 | Read address |
| rd_data | output | 32 | Stored word at `rd_addr` (combinational) |

## Verification
`in_ready` is combinational and is due in the same cycle as the inputs that drive it. The bench drives every input at the falling edge and samples `in_ready` one time unit later. The write bus, `wr_ptr` and `wrap_pulse` are due one rising edge after the cycle that completes a pair or flushes. Memory contents are due one rising edge after the second cycle in which `mem_we` is high. A behavioural model advances once for each rising edge, and the bench compares the registered outputs to it at the next falling edge. For the directed cases, a value is always checked at the falling edge that comes after the edge where it must appear.

// File: rtl/ppw_pkg.sv
package ppw_pkg;

  // State of the two-cycle write window in the holding stage
  typedef enum logic [1:0] {
    WIN_IDLE   = 2'd0,
    WIN_OPEN   = 2'd1,
    WIN_COMMIT = 2'd2
  } win_state_e;

endpackage

// File: rtl/ppw_assembler.sv
module ppw_assembler #(
  parameter int HALF_W = 16,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [HALF_W-1:0] in_data,
  output logic              in_ready,
  input  logic              flush,
  input  logic              stage_free,
  output logic              xfer,
  output logic [WORD_W-1:0] xfer_data
);

  logic              phase_q;   // 1: a lower half is waiting
  logic [HALF_W-1:0] low_q;
  logic              do_flush;
  logic              accept;

  assign do_flush  = phase_q && flush && stage_free;
  assign in_ready  = !phase_q || (stage_free && !flush);
  assign accept    = in_valid && in_ready;
  assign xfer      = (accept && phase_q) || do_flush;
  assign xfer_data = do_flush ? {{HALF_W{1'b0}}, low_q} : {in_data, low_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      low_q   <= '0;
    end else begin
      if (accept) begin
        phase_q <= ~phase_q;
      end else if (do_flush) begin
        phase_q <= 1'b0;
      end
      if (accept && !phase_q) begin
        low_q <= in_data;
      end
    end
  end

  // R9: a stalled offer leaves the waiting lower half untouched
  a_r9_stall_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> $stable(low_q));

  // R8: a flush with nothing waiting leaves the phase alone when no input is taken
  a_r8_idle_flush_no_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !phase_q && !in_valid) |=> !phase_q);

endmodule

// File: rtl/ppw_write_stage.sv
module ppw_write_stage
  import ppw_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer,
  input  logic [WORD_W-1:0] xfer_data,
  output logic              stage_free,
  output logic              commit,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [AW-1:0]     wr_ptr,
  output logic              wrap_pulse
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  win_state_e        st_q;
  logic [WORD_W-1:0] hold_data_q;
  logic [AW-1:0]     hold_addr_q;
  logic [AW-1:0]     ptr_q;
  logic              wrap_q;

  assign stage_free = (st_q != WIN_OPEN);
  assign commit     = (st_q == WIN_COMMIT);
  assign mem_we     = (st_q != WIN_IDLE);
  assign mem_addr   = hold_addr_q;
  assign mem_wdata  = hold_data_q;
  assign wr_ptr     = ptr_q;
  assign wrap_pulse = wrap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= WIN_IDLE;
      hold_data_q <= '0;
      hold_addr_q <= '0;
      ptr_q       <= '0;
      wrap_q      <= 1'b0;
    end else if (xfer) begin
      st_q        <= WIN_OPEN;
      hold_data_q <= xfer_data;
      hold_addr_q <= ptr_q;
      ptr_q       <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      wrap_q      <= (ptr_q == LAST);
    end else begin
      st_q   <= (st_q == WIN_OPEN) ? WIN_COMMIT : WIN_IDLE;
      wrap_q <= 1'b0;
    end
  end

  a_r3_we_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |=> mem_we);

  a_r3_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WIN_OPEN) |=> ($stable(mem_wdata) && $stable(mem_addr) && mem_we));

  a_r5_addr_from_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> (mem_addr == $past(wr_ptr)));

  a_r5_wrap_single: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |=> !wrap_pulse);

  a_r5_wrap_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> (wr_ptr == '0));

endmodule

// File: rtl/ppw_word_mem.sv
module ppw_word_mem #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              commit,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (commit && (waddr == AW'(g))) begin
        cells[g] <= wdata;
      end
    end
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/pair_pack_writer.sv
module pair_pack_writer #(
  parameter int HALF_W = 16,
  parameter int DEPTH  = 128,
  localparam int WORD_W = 2 * HALF_W,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [HALF_W-1:0] in_data,
  input  logic              flush,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [AW-1:0]     wr_ptr,
  output logic              wrap_pulse,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  logic              xfer;
  logic [WORD_W-1:0] xfer_data;
  logic              stage_free;
  logic              commit;

  ppw_assembler #(.HALF_W(HALF_W)) u_asm (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .flush      (flush),
    .stage_free (stage_free),
    .xfer       (xfer),
    .xfer_data  (xfer_data)
  );

  ppw_write_stage #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer       (xfer),
    .xfer_data  (xfer_data),
    .stage_free (stage_free),
    .commit     (commit),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .wr_ptr     (wr_ptr),
    .wrap_pulse (wrap_pulse)
  );

  ppw_word_mem #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_mem (
    .clk    (clk),
    .commit (commit),
    .waddr  (mem_addr),
    .wdata  (mem_wdata),
    .raddr  (rd_addr),
    .rdata  (rd_data)
  );

  // R6: the assembler never hands a word to a holding stage still in its first write cycle
  a_r6_handoff_into_free: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> stage_free);

  // R7: a flush that is honoured starts a write window on the next cycle
  a_r7_flush_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !in_ready) |=> (mem_we && $rose(mem_we) == !$past(mem_we)));

endmodule

// File: tb/pair_pack_writer_test.sv
module pair_pack_writer_test;
  localparam int PERIOD = 10;
  localparam int HW     = 16;
  localparam int DEPTH  = 128;
  localparam int AW     = 7;
  localparam int WW     = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [HW-1:0] in_data;
  logic          flush;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [WW-1:0] mem_wdata;
  logic [AW-1:0] wr_ptr;
  logic          wrap_pulse;
  logic [AW-1:0] rd_addr;
  logic [WW-1:0] rd_data;

  pair_pack_writer uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .flush(flush), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .wr_ptr(wr_ptr), .wrap_pulse(wrap_pulse),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #(PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // behavioural reference state
  bit            m_waiting;
  logic [HW-1:0] m_low;
  int            m_win;        // cycles of the write window already shown
  logic [AW-1:0] m_addr;
  logic [WW-1:0] m_data;
  int            m_ptr;
  bit            m_wrap;
  logic [WW-1:0] m_mem [DEPTH];
  bit            m_set [DEPTH];

  task automatic check(input bit ok, input string tag, input logic [WW-1:0] act,
                       input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_outputs();
    check(mem_we == (m_win != 0), "R3 mem_we", WW'(mem_we), WW'(m_win != 0));
    if (m_win != 0) begin
      check(mem_addr == m_addr, "R5 mem_addr", WW'(mem_addr), WW'(m_addr));
      check(mem_wdata == m_data, "R2 mem_wdata", mem_wdata, m_data);
    end
    check(int'(wr_ptr) == m_ptr, "R5 wr_ptr", WW'(wr_ptr), WW'(m_ptr));
    check(wrap_pulse == m_wrap, "R5 wrap_pulse", WW'(wrap_pulse), WW'(m_wrap));
  endtask

  // one clock: compare, drive at the falling edge, check ready, advance the model
  task automatic step(input bit v, input logic [HW-1:0] d, input bit f, output bit taken);
    bit rdy, flushing, acc, handoff;
    logic [WW-1:0] word;
    @(negedge clk);
    compare_outputs();
    in_valid = v; in_data = d; flush = f;
    #1;
    flushing = f && m_waiting;
    rdy      = !flushing;
    check(in_ready == rdy, flushing ? "R7 in_ready" : "R6 in_ready", WW'(in_ready), WW'(rdy));
    acc     = v && rdy;
    handoff = (acc && m_waiting) || flushing;
    word    = flushing ? {16'h0000, m_low} : {d, m_low};
    if (m_win == 2) begin
      m_mem[m_addr] = m_data;
      m_set[m_addr] = 1'b1;
    end
    if (handoff) begin
      m_data = word;
      m_addr = AW'(m_ptr);
      m_wrap = (m_ptr == DEPTH - 1);
      m_ptr  = (m_ptr + 1) % DEPTH;
      m_win  = 1;
    end else begin
      m_wrap = 1'b0;
      m_win  = (m_win == 1) ? 2 : 0;
    end
    if (acc) begin
      if (!m_waiting) m_low = d;
      m_waiting = !m_waiting;
    end else if (flushing) begin
      m_waiting = 1'b0;
    end
    taken = acc;
  endtask

  task automatic idle(input int n);
    bit t;
    for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, t);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    bit t;
    int taken_n, wraps;
    logic [HW-1:0] pend_d;
    bit pend_v;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; flush = 1'b0; rd_addr = '0;
    m_waiting = 0; m_low = '0; m_win = 0; m_addr = '0; m_data = '0; m_ptr = 0; m_wrap = 0;
    for (int i = 0; i < DEPTH; i++) m_set[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(mem_we == 1'b0, "R1 mem_we", WW'(mem_we), 0);
    check(wr_ptr == '0, "R1 wr_ptr", WW'(wr_ptr), 0);
    check(wrap_pulse == 1'b0, "R1 wrap_pulse", WW'(wrap_pulse), 0);
    check(in_ready == 1'b1, "R1 in_ready", WW'(in_ready), 1);

    // R2/R3/R4: one pair, window, commit
    step(1'b1, 16'h1111, 1'b0, t);
    step(1'b1, 16'h2222, 1'b0, t);
    step(1'b0, '0, 1'b0, t);
    check(mem_wdata == 32'h2222_1111, "R2 packing order", mem_wdata, 32'h2222_1111);
    check(mem_we == 1'b1, "R3 window first cycle", WW'(mem_we), 1);
    step(1'b0, '0, 1'b0, t);
    check(mem_we == 1'b1 && mem_wdata == 32'h2222_1111, "R3 window second cycle",
          mem_wdata, 32'h2222_1111);
    step(1'b0, '0, 1'b0, t);
    check(mem_we == 1'b0, "R3 window closed", WW'(mem_we), 0);
    check(rd_data == 32'h2222_1111, "R4 stored after commit", rd_data, 32'h2222_1111);

    // R8: flush with nothing waiting
    step(1'b0, '0, 1'b1, t);
    check(in_ready == 1'b1, "R8 ready kept", WW'(in_ready), 1);
    step(1'b0, '0, 1'b0, t);
    check(mem_we == 1'b0, "R8 no write", WW'(mem_we), 0);
    check(wr_ptr == 7'd1, "R8 ptr unchanged", WW'(wr_ptr), 1);

    // R7: flush of a lone half-word
    step(1'b1, 16'hC0DE, 1'b0, t);
    step(1'b0, '0, 1'b1, t);
    check(in_ready == 1'b0, "R7 ready low on flush", WW'(in_ready), 0);
    step(1'b0, '0, 1'b0, t);
    check(mem_wdata == 32'h0000_C0DE, "R7 zero upper half", mem_wdata, 32'h0000_C0DE);
    check(mem_addr == 7'd1, "R7 flush address", WW'(mem_addr), 1);
    idle(2);

    // R9: offer during flush is not taken, then becomes a new first half
    step(1'b1, 16'hD00D, 1'b0, t);
    step(1'b1, 16'hEEEE, 1'b1, t);
    check(t == 1'b0, "R9 offer refused", WW'(t), 0);
    step(1'b1, 16'hEEEE, 1'b0, t);
    check(t == 1'b1, "R9 offer taken later", WW'(t), 1);
    check(mem_wdata == 32'h0000_D00D, "R9 flushed word", mem_wdata, 32'h0000_D00D);
    step(1'b1, 16'hFFFF, 1'b0, t);
    step(1'b0, '0, 1'b0, t);
    check(mem_wdata == 32'hFFFF_EEEE, "R9 stalled word leads pair", mem_wdata, 32'hFFFF_EEEE);
    idle(2);

    // R6/R5: full-rate burst across the address rollover
    taken_n = 0; wraps = 0;
    for (int i = 0; i < 300; i++) begin
      step(1'b1, HW'(i * 37 + 5), 1'b0, t);
      taken_n += int'(t);
      if (wrap_pulse) wraps++;
    end
    idle(3);
    check(taken_n == 300, "R6 full rate accepted", WW'(taken_n), 300);
    check(wraps >= 1, "R5 wrap seen", WW'(wraps), 1);

    // mixed traffic with gaps and flushes
    pend_v = 1'b0; pend_d = '0;
    for (int i = 0; i < 3000; i++) begin
      bit v, f;
      logic [HW-1:0] d;
      if (pend_v) begin
        v = 1'b1; d = pend_d;
      end else begin
        v = ($urandom_range(0, 9) < 7);
        d = HW'($urandom);
      end
      f = ($urandom_range(0, 9) == 0);
      step(v, d, f, t);
      pend_v = v && !t;
      pend_d = d;
    end
    idle(4);

    // R4: final memory contents
    for (int a = 0; a < DEPTH; a++) begin
      if (m_set[a]) begin
        @(negedge clk);
        rd_addr = AW'(a);
        #1;
        check(rd_data == m_mem[a], "R4 memory content", rd_data, m_mem[a]);
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule